// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block keeps one data pointer and produces the byte effective address for each access made through it, together with the pointer value that the access will leave behind. The address space is a flat byte space of 16 Mbytes, so the pointer is 24 bits wide. Each access names a size (byte, 16-bit word or 32-bit long word) and an update mode. The step that the pointer moves by follows from the size.

Five update modes are offered. Two are plain post-increment and post-decrement, and these wrap freely around the top and bottom of the space. Two keep the pointer inside a circular buffer bounded by a start and an end register. The last mode steps the pointer in bit-reversed order, adding a modifier with the carry running toward the least significant bit, which is how FFT results are put back in natural order. Bit-reversed stepping exists only on an instance built with the parameter that enables it, which is meant for the write-side unit. On any other instance a bit-reversed request is treated as a linear increment.

The pointer is a register. It changes on a clock edge only when an access strobe or a load strobe is high, and a synchronous reset clears it. The effective address of the current access is the register value. The next-pointer output is combinational, so the instruction pipeline can see the post-update value during the same cycle.

Top module: `agu_circ_bitrev`

## Requirements
- R1: While `rst` is high at a clock edge, `ea` becomes 0 after that edge.
- R2: When neither `acc_en` nor `ld_en` is high at an edge, `ea` keeps its value.
- R3: When `ld_en` is high at an edge, `ea` takes `ld_val`. This holds even when `acc_en` is also high.
- R4: When `acc_en` is high and `ld_en` is low at an edge, `ea` takes the `next_ptr` value shown before that edge.
- R5: The size code `acc_size` gives the step: 0 is byte (1), 1 is word (2), and 2 or 3 is long word (4). Mode 0 adds the step and mode 1 subtracts it.
- R6: Linear results wrap modulo 2^24. Adding 4 to 0xFFFFFC gives 0, and subtracting 1 from 0 gives 0xFFFFFF.
- R7: Mode 2 is circular increment. Both bounds are first aligned down to the step. If the pointer plus the step is above the aligned end, the result is the aligned start; otherwise it is the plain sum.
- R8: Mode 3 is circular decrement. If the pointer minus the step is below the aligned start, or would go below address 0, the result is the aligned end; otherwise it is the plain difference.
- R9: Mode 4 is bit-reversed stepping when `BITREV_EN` is 1. The index is the pointer shifted right by log2 of the step. The modifier `br_mod`, given in index units, is added to that index with the carry running from the most significant bit toward bit 0, and any carry out of bit 0 is dropped. The result is shifted back, and the pointer's low sub-size bits are kept unchanged.
- R10: With `BITREV_EN` equal to 0, mode 4 behaves exactly as mode 0.
- R11: Modes 5, 6 and 7 leave the pointer unchanged, so `next_ptr` equals `ea`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access strobe; the pointer takes `next_ptr` at the edge |
| ld_en | input | 1 | Load strobe; has priority over `acc_en` |
| ld_val | input | 24 | Value to load into the pointer |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 or 3 long word |
| upd_mode | input | 3 | 0 inc, 1 dec, 2 circular inc, 3 circular dec, 4 bit-reversed, 5 to 7 hold |
| buf_start | input | 24 | Circular buffer start (lowest byte address) |
| buf_end | input | 24 | Circular buffer end (highest byte address) |
| br_mod | input | 24 | Bit-reverse modifier, in index units |
| ea | output | 24 | Effective address of the current access (pointer register) |
| next_ptr | output | 24 | Pointer value after the current access |

## Verification
`next_ptr` is combinational from `ea` and the control inputs, so it is due in the same cycle. The bench reads it one time unit after driving inputs at the falling edge, before any rising edge can move the pointer. `ea` is a single register stage: after a load, an access or a reset, the new value is due one rising edge later, and it is read at the following falling edge. Each table vector therefore checks `next_ptr` first and then checks `ea` one edge after the strobe. The multi-step circular walk checks every intermediate pointer the same way.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        MD_LIN_INC = 3'd0,
        MD_LIN_DEC = 3'd1,
        MD_MOD_INC = 3'd2,
        MD_MOD_DEC = 3'd3,
        MD_BITREV  = 3'd4,
        MD_RSV5    = 3'd5,
        MD_RSV6    = 3'd6,
        MD_RSV7    = 3'd7
    } upd_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    // log2 of the step in bytes
    function automatic logic [1:0] size_shift(input acc_size_e sz);
        unique case (sz)
            SZ_BYTE: return 2'd0;
            SZ_WORD: return 2'd1;
            SZ_LONG: return 2'd2;
            SZ_WIDE: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/agu_circ_step.sv
module agu_circ_step #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    shamt,
    input  logic          dir_dec,
    input  logic          wrap_en,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] step;
    logic [AW-1:0] keep_mask;
    logic [AW-1:0] lo_al;
    logic [AW-1:0] hi_al;
    logic [AW:0]   sum_w;
    logic [AW:0]   dif_w;
    logic          inc_wrap;
    logic          dec_wrap;

    always_comb begin
        step      = ONE << shamt;
        keep_mask = ~(step - ONE);
        lo_al     = lo_bound & keep_mask;
        hi_al     = hi_bound & keep_mask;
        sum_w     = {1'b0, cur} + {1'b0, step};
        dif_w     = {1'b0, cur} - {1'b0, step};
        inc_wrap  = wrap_en && (sum_w > {1'b0, hi_al});
        dec_wrap  = wrap_en && (dif_w[AW] || (dif_w[AW-1:0] < lo_al));
        if (dir_dec)
            nxt = dec_wrap ? hi_al : dif_w[AW-1:0];
        else
            nxt = inc_wrap ? lo_al : sum_w[AW-1:0];
    end

endmodule

// File: rtl/agu_revcarry.sv
module agu_revcarry #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    shamt,
    input  logic [AW-1:0] modifier,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    // addition with carry travelling toward bit 0
    function automatic logic [AW-1:0] rc_add(input logic [AW-1:0] a,
                                              input logic [AW-1:0] b);
        logic [AW-1:0] s;
        logic c;
        c = 1'b0;
        s = '0;
        for (int i = AW - 1; i >= 0; i--) begin
            s[i] = a[i] ^ b[i] ^ c;
            c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        return s;
    endfunction

    logic [AW-1:0] idx;
    logic [AW-1:0] low_mask;

    always_comb begin
        idx      = cur >> shamt;
        low_mask = (ONE << shamt) - ONE;
        nxt      = (rc_add(idx, modifier) << shamt) | (cur & low_mask);
    end

endmodule

// File: rtl/agu_circ_bitrev.sv
module agu_circ_bitrev #(
    parameter int AW        = 24,
    parameter bit BITREV_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_en,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_val,
    input  logic [1:0]    acc_size,
    input  logic [2:0]    upd_mode,
    input  logic [AW-1:0] buf_start,
    input  logic [AW-1:0] buf_end,
    input  logic [AW-1:0] br_mod,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] next_ptr
);
    import agu_pkg::*;

    upd_mode_e     mode_q;
    logic [1:0]    shamt;
    logic          dir_dec;
    logic          wrap_en;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] circ_nxt;
    logic [AW-1:0] br_nxt;

    assign mode_q  = upd_mode_e'(upd_mode);
    assign shamt   = size_shift(acc_size_e'(acc_size));
    assign dir_dec = (mode_q == MD_LIN_DEC) || (mode_q == MD_MOD_DEC);
    assign wrap_en = (mode_q == MD_MOD_INC) || (mode_q == MD_MOD_DEC);

    agu_circ_step #(.AW(AW)) u_circ (
        .cur      (ptr_q),
        .shamt    (shamt),
        .dir_dec  (dir_dec),
        .wrap_en  (wrap_en),
        .lo_bound (buf_start),
        .hi_bound (buf_end),
        .nxt      (circ_nxt)
    );

    generate
        if (BITREV_EN) begin : g_br
            agu_revcarry #(.AW(AW)) u_rev (
                .cur      (ptr_q),
                .shamt    (shamt),
                .modifier (br_mod),
                .nxt      (br_nxt)
            );
        end else begin : g_nobr
            // mode 4 falls back to linear increment (circ unit: dir 0, no wrap)
            assign br_nxt = circ_nxt;
        end
    endgenerate

    // next-pointer selection
    always_comb begin
        unique case (mode_q)
            MD_LIN_INC, MD_LIN_DEC,
            MD_MOD_INC, MD_MOD_DEC:       next_ptr = circ_nxt;
            MD_BITREV:                    next_ptr = br_nxt;
            MD_RSV5, MD_RSV6, MD_RSV7:    next_ptr = ptr_q;
        endcase
    end

    // pointer register
    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (ld_en)
            ptr_q <= ld_val;
        else if (acc_en)
            ptr_q <= next_ptr;
    end

    assign ea = ptr_q;

    // ---------------- assertions ----------------
    localparam logic [AW-1:0] ONE = AW'(1);
    logic [AW-1:0] chk_mask;
    logic [AW-1:0] chk_lo;
    logic [AW-1:0] chk_hi;
    assign chk_mask = ~((ONE << shamt) - ONE);
    assign chk_lo   = buf_start & chk_mask;
    assign chk_hi   = buf_end & chk_mask;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (ea == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!acc_en && !ld_en) |=> $stable(ea));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (ea == $past(ld_val)));

    assert_follow_next_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !ld_en) |=> (ea == $past(next_ptr)));

    assert_circ_inc_stays_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !ld_en && mode_q == MD_MOD_INC && ea >= chk_lo && ea <= chk_hi)
        |=> (ea >= $past(chk_lo) && ea <= $past(chk_hi)));

    assert_circ_dec_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !ld_en && mode_q == MD_MOD_DEC && ea >= chk_lo && ea <= chk_hi)
        |=> (ea >= $past(chk_lo) && ea <= $past(chk_hi)));

    assert_reserved_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !ld_en && upd_mode >= 3'd5) |=> $stable(ea));

endmodule

// File: tb/agu_circ_bitrev_bench.sv
module agu_circ_bitrev_bench;

    localparam int AW = 24;
    localparam int NV = 18;
    // vector: mode[124:122] size[121:120] ptr[119:96] start[95:72] end[71:48] mod[47:24] exp[23:0]
    localparam logic [124:0] VEC [NV] = '{
        {3'd0, 2'd0, 24'h000100, 24'h0, 24'h0, 24'h0, 24'h000101},            // R5 byte inc
        {3'd0, 2'd1, 24'h000100, 24'h0, 24'h0, 24'h0, 24'h000102},            // R5 word inc
        {3'd0, 2'd2, 24'h000100, 24'h0, 24'h0, 24'h0, 24'h000104},            // R5 long inc
        {3'd1, 2'd2, 24'h000100, 24'h0, 24'h0, 24'h0, 24'h0000FC},            // R5 long dec
        {3'd0, 2'd2, 24'hFFFFFC, 24'h0, 24'h0, 24'h0, 24'h000000},            // R6 top wrap
        {3'd1, 2'd0, 24'h000000, 24'h0, 24'h0, 24'h0, 24'hFFFFFF},            // R6 bottom wrap
        {3'd2, 2'd1, 24'h00020E, 24'h000200, 24'h00020F, 24'h0, 24'h000200},  // R7 wrap
        {3'd2, 2'd1, 24'h000208, 24'h000200, 24'h00020F, 24'h0, 24'h00020A},  // R7 no wrap
        {3'd2, 2'd2, 24'h00020C, 24'h000201, 24'h00020F, 24'h0, 24'h000200},  // R7 aligned bounds
        {3'd3, 2'd2, 24'h000200, 24'h000200, 24'h00020F, 24'h0, 24'h00020C},  // R8 wrap
        {3'd3, 2'd0, 24'h000000, 24'h000000, 24'h00000F, 24'h0, 24'h00000F},  // R8 below zero
        {3'd3, 2'd1, 24'h000206, 24'h000200, 24'h00020F, 24'h0, 24'h000204},  // R8 no wrap
        {3'd4, 2'd1, 24'h001000, 24'h0, 24'h0, 24'h000008, 24'h001010},       // R9 no carry
        {3'd4, 2'd1, 24'h001010, 24'h0, 24'h0, 24'h000008, 24'h001008},       // R9 carry down
        {3'd4, 2'd2, 24'h001020, 24'h0, 24'h0, 24'h000008, 24'h001010},       // R9 long
        {3'd4, 2'd0, 24'h00000F, 24'h0, 24'h0, 24'h000008, 24'h000000},       // R9 carry out dropped
        {3'd4, 2'd1, 24'h001011, 24'h0, 24'h0, 24'h000008, 24'h001009},       // R9 low bit kept
        {3'd5, 2'd2, 24'h123456, 24'h0, 24'h0, 24'h0, 24'h123456}             // R11 reserved hold
    };
    localparam string TAGS [NV] = '{"R5", "R5", "R5", "R5", "R6", "R6",
                                     "R7", "R7", "R7", "R8", "R8", "R8",
                                     "R9", "R9", "R9", "R9", "R9", "R11"};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_en = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_val = '0;
    logic [1:0]    acc_size = 2'd0;
    logic [2:0]    upd_mode = 3'd0;
    logic [AW-1:0] buf_start = '0;
    logic [AW-1:0] buf_end = '0;
    logic [AW-1:0] br_mod = '0;
    logic [AW-1:0] ea, next_ptr, ea_nb, next_nb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    agu_circ_bitrev #(.AW(AW), .BITREV_EN(1'b1)) u_agu_circ_bitrev (
        .clk(clk), .rst(rst), .acc_en(acc_en), .ld_en(ld_en), .ld_val(ld_val),
        .acc_size(acc_size), .upd_mode(upd_mode), .buf_start(buf_start),
        .buf_end(buf_end), .br_mod(br_mod), .ea(ea), .next_ptr(next_ptr));

    agu_circ_bitrev #(.AW(AW), .BITREV_EN(1'b0)) u_agu_circ_bitrev_nobr (
        .clk(clk), .rst(rst), .acc_en(acc_en), .ld_en(ld_en), .ld_val(ld_val),
        .acc_size(acc_size), .upd_mode(upd_mode), .buf_start(buf_start),
        .buf_end(buf_end), .br_mod(br_mod), .ea(ea_nb), .next_ptr(next_nb));

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        #1 check("R1 reset state", ea, '0);
        rst = 1'b0;

        // table walk: load, check comb next, strobe, check registered ea
        for (int k = 0; k < NV; k++) begin
            load(VEC[k][119:96]);
            upd_mode  = VEC[k][124:122];
            acc_size  = VEC[k][121:120];
            buf_start = VEC[k][95:72];
            buf_end   = VEC[k][71:48];
            br_mod    = VEC[k][47:24];
            #1 check({TAGS[k], " next_ptr"}, next_ptr, VEC[k][23:0]);
            acc_en = 1'b1;
            @(negedge clk);
            acc_en = 1'b0;
            #1 check({TAGS[k], " ea after access (R4)"}, ea, VEC[k][23:0]);
        end

        // R10: instance without bit-reverse treats mode 4 as linear increment
        load(24'h001000);
        upd_mode = 3'd4; acc_size = 2'd1; br_mod = 24'h000008;
        #1 check("R10 nobr next_ptr", next_nb, 24'h001002);
        check("R9 br next_ptr same inputs", next_ptr, 24'h001010);

        // R2: idle edges keep the pointer
        upd_mode = 3'd0; acc_size = 2'd2;
        repeat (3) @(negedge clk);
        #1 check("R2 idle hold", ea, 24'h001000);

        // R3: load has priority over access
        @(negedge clk);
        ld_en = 1'b1; acc_en = 1'b1; ld_val = 24'h0ABCDE;
        @(negedge clk);
        ld_en = 1'b0; acc_en = 1'b0;
        #1 check("R3 load priority", ea, 24'h0ABCDE);

        // R7/R8 multi-step circular walk, long words in 0x300..0x307
        load(24'h000300);
        upd_mode = 3'd2; acc_size = 2'd2; buf_start = 24'h000300; buf_end = 24'h000307;
        acc_en = 1'b1;
        @(negedge clk); #1 check("R7 walk step1", ea, 24'h000304);
        @(negedge clk); #1 check("R7 walk step2", ea, 24'h000300);
        @(negedge clk); #1 check("R7 walk step3", ea, 24'h000304);
        upd_mode = 3'd3;
        @(negedge clk); #1 check("R8 walk step4", ea, 24'h000300);
        @(negedge clk); #1 check("R8 walk step5", ea, 24'h000304);
        acc_en = 1'b0;

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk); #1 check("R1 reset mid-run", ea, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule